// File: doc/BRIEF.md
# MDIO Management Register Interface

This block gives software one 32-bit control/status word for reaching the management registers of an external PHY over the two-wire MDC/MDIO bus, using clause-22 framing. Software writes the word with a PHY address, a register address, optional write data and a command bit. The block then serialises a complete management frame on MDIO, clocked by an MDC that it derives from the system clock. While the frame is on the wire, a busy flag reads as 1.

When a read completes, the 16 data bits returned by the PHY appear in the upper half of the same word. A not-valid flag shows whether the PHY answered at all: if no PHY pulls the line low during the turnaround, the flag is set. Software polls busy before issuing a command and again to detect completion. Any write that arrives while busy is set is dropped.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, the register reads as: data field [31:16] = 0, PHY address field [15:11] = parameter PHY_ADDR_RST, register field [10:6] = 0, not-valid (bit 4) = 0, busy (bit 3) = 0. MDC is low and the MDIO output enable is low.
- R2: A write accepted while idle loads [31:16], [15:11] and [10:6] from the written word. Bits 1:0 are command bits, and bits 5, 2, 1 and 0 always read as 0. A write with both command bits clear starts nothing.
- R3: Setting bit 0 starts a write frame, sent MSB first with one bit per MDC period. The frame is 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, then the 16 data bits.
- R4: Setting bit 1 starts a read frame, whose first 46 bits are 32 ones, 01, opcode 10, the PHY address and the register address. The output enable is high for those 46 bits and low for the remaining 18 bits.
- R5: On a read, the 16 bits sampled on the rising MDC edges after the turnaround land MSB first in [31:16] when busy clears. Not-valid is 0 if the second turnaround bit was sampled low.
- R6: Not-valid is set at the end of a read whose second turnaround bit was sampled high. It is cleared when the next command starts.
- R7: Busy reads 1 from the cycle after an accepted command write, and stays 1 for exactly 128*MDC_HALF_DIV clock cycles.
- R8: MDC has a period of 2*MDC_HALF_DIV clock cycles during a frame and is low while idle. MDIO output changes only together with a falling MDC edge.
- R9: A register write while busy is 1 has no effect: the fields keep their values and no further frame starts.
- R10: If bits 1 and 0 are both set, the command is a read.
- R11: While idle, the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench acts as the PHY. It decodes every frame bit on rising MDC and answers reads after the turnaround, including a case where no PHY responds. This checks that the turnaround sample lands on the right bit: an off-by-one would either fail to raise not-valid or shift the returned data by one place. Sweeps over addresses and data expose a swapped opcode or address field, and a frame that is one period short or long shows up as a wrong busy length. A command written in the middle of a read must neither corrupt the fields nor start a second frame. The bench also issues a command with both command bits set and confirms it runs as a read, not a write.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam logic [IDX_W-1:0] IDX_TA1  = IDX_W'(46);
  localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(47);
  localparam logic [IDX_W-1:0] IDX_D0   = IDX_W'(48);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } opcode_e;

  function automatic logic [FRAME_BITS-1:0] make_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] ra,
    input logic [DATA_W-1:0] wd
  );
    opcode_e             opc;
    logic [1:0]          ta;
    logic [DATA_W-1:0]   body;
    opc  = rd ? OPC_READ : OPC_WRITE;
    ta   = rd ? 2'b11 : 2'b10;
    body = rd ? {DATA_W{1'b1}} : wd;
    return {{32{1'b1}}, 2'b01, opc, phy, ra, ta, body};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  logic edge_now;
  logic mdc_q, mdc_d;

  generate
    if (HALF_DIV <= 1) begin : g_every_cycle
      assign edge_now = run_i;
    end else begin : g_counted
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (!run_i || (cnt_q == LAST)) cnt_d = '0;
        else                           cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign edge_now = run_i && (cnt_q == LAST);
    end
  endgenerate

  always_comb begin
    if (!run_i)        mdc_d = 1'b0;
    else if (edge_now) mdc_d = ~mdc_q;
    else               mdc_d = mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc_d;
  end

  assign mdc_o  = mdc_q;
  assign rise_o = edge_now & ~mdc_q;
  assign fall_o = edge_now &  mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] ra_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ta_bad_o
);
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]     rx_q, rx_d;
  logic                  tab_q, tab_d;
  logic                  done_c;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    tab_d  = tab_q;
    done_c = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        rd_d   = rd_i;
        idx_d  = '0;
        sh_d   = make_frame(rd_i, phy_i, ra_i, wdata_i);
        tab_d  = 1'b0;
      end
    end else begin
      if (rise_i && rd_q) begin
        if (idx_q == IDX_TA2) tab_d = mdio_i;
        if (idx_q >= IDX_D0)  rx_d  = {rx_q[DATA_W-2:0], mdio_i};
      end
      if (fall_i) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
          done_c = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      rx_q   <= '0;
      tab_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      tab_q  <= tab_d;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_c;
  assign rd_o      = rd_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q >= IDX_TA1));
  assign rdata_o   = rx_d;
  assign ta_bad_o  = tab_q;
endmodule

// File: rtl/mdio_mgmt.sv
`timescale 1ns/1ps
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int          MDC_HALF_DIV = 25,
  parameter logic [4:0]  PHY_ADDR_RST = 5'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [DATA_W-1:0] data_q, data_d;
  logic [ADDR_W-1:0] phy_q, phy_d;
  logic [ADDR_W-1:0] ra_q, ra_d;
  logic              nval_q, nval_d;

  logic              busy, done, eng_rd, ta_bad;
  logic              rise, fall;
  logic [DATA_W-1:0] eng_rx;
  logic              accept, start, cmd_rd;

  assign accept = reg_wr && !busy;
  assign start  = accept && (reg_wdata[1] || reg_wdata[0]);
  assign cmd_rd = reg_wdata[1];

  mdio_clkgen #(.HALF_DIV(MDC_HALF_DIV)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .mdc_o  (mdc),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .rd_i      (cmd_rd),
    .phy_i     (reg_wdata[15:11]),
    .ra_i      (reg_wdata[10:6]),
    .wdata_i   (reg_wdata[31:16]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .rd_o      (eng_rd),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe),
    .rdata_o   (eng_rx),
    .ta_bad_o  (ta_bad)
  );

  always_comb begin
    data_d = data_q;
    phy_d  = phy_q;
    ra_d   = ra_q;
    nval_d = nval_q;
    if (accept) begin
      data_d = reg_wdata[31:16];
      phy_d  = reg_wdata[15:11];
      ra_d   = reg_wdata[10:6];
      if (start) nval_d = 1'b0;
    end
    if (done && eng_rd) begin
      data_d = eng_rx;
      nval_d = ta_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      phy_q  <= PHY_ADDR_RST;
      ra_q   <= '0;
      nval_q <= 1'b0;
    end else begin
      data_q <= data_d;
      phy_q  <= phy_d;
      ra_q   <= ra_d;
      nval_q <= nval_d;
    end
  end

  assign reg_rdata = {data_q, phy_q, ra_q, 1'b0, nval_q, busy, 3'b000};
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk #(
  parameter int HALF_DIV = 25
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  localparam int BUSY_CYCLES = 128 * HALF_DIV;
  logic       busy;
  logic [31:0] busy_cnt;
  assign busy = reg_rdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == BUSY_CYCLES));

  a_r9_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(reg_rdata[15:6]));

  a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r8_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r8_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdc == $past(mdc))) |-> $stable(mdio_o));

  a_r6_nvalid_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !reg_rdata[4]);
endmodule

bind mdio_mgmt mdio_mgmt_chk #(.HALF_DIV(MDC_HALF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_mgmt.sv
`timescale 1ns/1ps
module tb_mdio_mgmt;
  localparam int         HD      = 2;
  localparam logic [4:0] PHY_RST = 5'd17;
  localparam int         BUSY_N  = 128 * HD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  logic [63:0] cap;
  int          rise_n;
  int          oe_bad;
  int          per_bad;
  time         last_rise;
  logic [15:0] rsp_data = '0;
  logic        rsp_ta = 1'b0;
  logic        rd_mode = 1'b0;

  mdio_mgmt #(.MDC_HALF_DIV(HD), .PHY_ADDR_RST(PHY_RST)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_o};
    if (rd_mode && rise_n >= 46) begin
      if (mdio_oe) oe_bad++;
    end else if (!mdio_oe) oe_bad++;
    if (rise_n > 0 && ($time - last_rise) != time'(2 * HD * 8)) per_bad++;
    last_rise = $time;
    rise_n++;
  end

  always @(negedge mdc) begin
    if (rise_n == 47)                       mdio_i = rsp_ta;
    else if (rise_n >= 48 && rise_n <= 63)  mdio_i = rsp_data[63 - rise_n];
    else                                    mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic rd, output int bcyc);
    @(negedge clk);
    rise_n = 0; oe_bad = 0; per_bad = 0; cap = '0; rd_mode = rd;
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
    bcyc = 0;
    while (reg_rdata[3]) begin
      bcyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [15:0] d, input logic [4:0] p,
                                      input logic [4:0] r, input logic [1:0] c);
    return {d, p, r, 4'b0000, c};
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bc;
    logic [4:0] p, r;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset word", reg_rdata, {16'h0, PHY_RST, 11'h0});
    chk("R1 mdc/oe", {mdc, mdio_oe}, 2'b00);

    // R2 field load without command
    issue(cmd(16'hA5C3, 5'd9, 5'd22, 2'b00), 1'b0, bc);
    chk("R2 readback", reg_rdata, {16'hA5C3, 5'd9, 5'd22, 6'b0});
    chk("R2 no busy", bc, 0);
    chk("R11 idle oe", mdio_oe, 1'b0);

    // R3 / R7 / R8 write sweep
    for (int i = 0; i < 8; i++) begin
      p = 5'((i * 5 + 1) % 32); r = 5'((i * 7 + 3) % 32);
      d = 16'h1234 ^ 16'(i * 16'h1111);
      issue(cmd(d, p, r, 2'b01), 1'b0, bc);
      chk("R3 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d});
      chk("R3 oe whole frame", oe_bad, 0);
      chk("R7 busy length", bc, BUSY_N);
      chk("R8 mdc period", per_bad, 0);
      chk("R6 nvalid after write", reg_rdata[4], 1'b0);
    end

    // R4 / R5 read sweep
    for (int i = 0; i < 8; i++) begin
      p = 5'((i * 3 + 2) % 32); r = 5'((i * 11 + 1) % 32);
      rsp_data = 16'hF00D ^ 16'(i * 16'h0707); rsp_ta = 1'b0;
      issue(cmd(16'h0, p, r, 2'b10), 1'b1, bc);
      chk("R4 read header", cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, p, r});
      chk("R4 release from turnaround", oe_bad, 0);
      chk("R5 read data", reg_rdata[31:16], rsp_data);
      chk("R5 nvalid clear", reg_rdata[4], 1'b0);
      chk("R7 read busy length", bc, BUSY_N);
    end

    // R6 no PHY answer
    rsp_data = 16'hFFFF; rsp_ta = 1'b1;
    issue(cmd(16'h0, 5'd30, 5'd2, 2'b10), 1'b1, bc);
    chk("R6 nvalid set", reg_rdata[4], 1'b1);
    rsp_ta = 1'b0; rsp_data = 16'h4321;
    issue(cmd(16'h0, 5'd30, 5'd2, 2'b10), 1'b1, bc);
    chk("R6 nvalid cleared by next read", reg_rdata[4], 1'b0);
    chk("R5 data after recovery", reg_rdata[31:16], 16'h4321);

    // R10 both command bits
    rsp_data = 16'h0BEE;
    issue(cmd(16'h7777, 5'd4, 5'd5, 2'b11), 1'b1, bc);
    chk("R10 opcode read", cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd4, 5'd5});
    chk("R10 data", reg_rdata[31:16], 16'h0BEE);

    // R9 write while busy
    rsp_data = 16'h5A5A;
    @(negedge clk);
    rise_n = 0; oe_bad = 0; cap = '0; rd_mode = 1'b1;
    reg_wr = 1'b1; reg_wdata = cmd(16'h0, 5'd12, 5'd13, 2'b10);
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (20) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = cmd(16'hDEAD, 5'd3, 5'd4, 2'b01);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 fields held mid-frame", reg_rdata[15:6], {5'd12, 5'd13});
    while (reg_rdata[3]) @(negedge clk);
    chk("R9 read result intact", reg_rdata, {16'h5A5A, 5'd12, 5'd13, 6'b0});
    repeat (40) @(negedge clk);
    chk("R9 no second frame", {reg_rdata[3], mdc, mdio_oe}, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule